// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines and one edge-triggered non-maskable request. It picks the most urgent request that outranks whatever is currently being serviced and raises a single request toward the CPU. When the CPU acknowledges, the controller announces the winner as an encoded line number, and the device compares that number with its own. The device then drives its vector, which the controller registers and hands to the CPU as an index into a handler table.

The level in service sits in a priority register backed by a stack of earlier levels, so handlers can nest. An end-of-interrupt pulse restores the level that was active before the current one. Line index 0 is the most urgent line. The non-maskable request outranks every line and ignores the priority register. It is held off only while another non-maskable request is itself in service. The stack holds one entry per line plus one for the non-maskable request, so a legal nesting chain never runs out of room.

Top module: `pvic_top`

## Requirements
- R1: After reset, `cpu_irq`, `ack_valid` and `vec_valid` are low and no level is in service, so any line is eligible.
- R2: `cpu_irq` rises one cycle after an eligible request appears. One cycle after a `cpu_ack` that is accepted, `ack_valid` pulses for one cycle with `ack_num` = i, meaning line index i (the lowest set index wins), and `cpu_irq` is low during that cycle.
- R3: Line i is eligible only when its index is strictly lower than the line index in service. Lines of equal or lower priority are held off and do not raise `cpu_irq`.
- R4: `eoi` restores the level that was in service before the current one, allowing arbitrarily nested returns. `eoi` with nothing in service is ignored.
- R5: A rising edge on `nmi_req` is latched and outranks every line regardless of the level in service. It is acknowledged with `ack_nmi`=1 and `ack_num`=0. While a non-maskable request is in service, a new one waits for `eoi`. A level held high does not retrigger.
- R6: One cycle after `ack_valid`, `vec_valid` pulses for one cycle with `vec_out` equal to the `dev_vector` sampled during the `ack_valid` cycle. For a non-maskable acknowledge, `vec_out` is the parameter `NMI_VECTOR` (252 by default).
- R7: A `cpu_ack` while no request is eligible is ignored: no `ack_valid` and no change of level.
- R8: When `eoi` and `cpu_ack` arrive in the same cycle, the `eoi` is applied and the acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | NUM_IRQ | Level request lines, index 0 most urgent |
| nmi_req | input | 1 | Non-maskable request, rising-edge sensitive |
| cpu_ack | input | 1 | CPU acknowledge pulse |
| eoi | input | 1 | End of interrupt, restores the previous level |
| dev_vector | input | VEC_W | Vector driven by the acknowledged device |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| ack_valid | output | 1 | Acknowledge number is valid this cycle |
| ack_num | output | ID_W | Encoded index of the accepted line |
| ack_nmi | output | 1 | The accepted request is the non-maskable one |
| vec_valid | output | 1 | Vector is valid this cycle |
| vec_out | output | VEC_W | Handler table index for the CPU |

## Verification
A change on the request lines shows on `cpu_irq` one cycle later, and an `nmi_req` edge shows two cycles later because the edge is latched first. An accepted acknowledge gives `ack_valid` one cycle after `cpu_ack` and `vec_valid` one cycle after that. An `eoi` changes the level at the next edge, so its effect on `cpu_irq` is visible one cycle after that. The bench drives every input at a falling edge and samples exactly that many falling edges later. It sweeps all 256 request patterns from idle, and all patterns against each of the eight levels in service.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  // handshake phase: waiting for an acknowledge, or presenting the accepted number
  typedef enum logic [0:0] {
    HS_IDLE = 1'b0,
    HS_ACK  = 1'b1
  } hs_state_e;
endpackage

// File: rtl/pvic_arbiter.sv
// Picks the most urgent eligible request. Level code 0 = non-maskable,
// code i+1 = line i, larger code = less urgent.
module pvic_arbiter #(
  parameter int NUM_IRQ = 8,
  parameter int ID_W    = 3,
  parameter int LVL_W   = 4
) (
  input  logic [NUM_IRQ-1:0] irq,
  input  logic               nmi_pend,
  input  logic [LVL_W-1:0]   cur_lvl,
  output logic               cand_valid,
  output logic               cand_nmi,
  output logic [ID_W-1:0]    cand_id,
  output logic [LVL_W-1:0]   cand_lvl
);
  logic [NUM_IRQ-1:0] elig;

  // per-line mask against the level in service (strictly more urgent only)
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_elig
    assign elig[g] = irq[g] && (LVL_W'(g + 1) < cur_lvl);
  end

  always_comb begin
    cand_valid = 1'b0;
    cand_nmi   = 1'b0;
    cand_id    = '0;
    cand_lvl   = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (elig[i]) begin
        cand_valid = 1'b1;
        cand_id    = ID_W'(i);
        cand_lvl   = LVL_W'(i + 1);
      end
    end
    if (nmi_pend && (cur_lvl != '0)) begin
      cand_valid = 1'b1;
      cand_nmi   = 1'b1;
      cand_id    = '0;
      cand_lvl   = '0;
    end
  end
endmodule

// File: rtl/pvic_level_stack.sv
// Priority register plus a stack of the levels it replaced.
module pvic_level_stack #(
  parameter int LVL_W    = 4,
  parameter int DEPTH    = 9,
  parameter int IDLE_LVL = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [LVL_W-1:0] cur_lvl,
  output logic             full,
  output logic             empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] stk_q [DEPTH];
  logic [LVL_W-1:0] cur_q, cur_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cur_n = cur_q;
    cnt_n = cnt_q;
    if (push) begin
      cur_n = push_lvl;
      cnt_n = cnt_q + CNT_W'(1);
    end else if (pop) begin
      cur_n = stk_q[cnt_q - CNT_W'(1)];
      cnt_n = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= LVL_W'(IDLE_LVL);
      cnt_q <= '0;
    end else begin
      cur_q <= cur_n;
      cnt_q <= cnt_n;
    end
  end

  // storage needs no reset: an entry is read only after it was written
  always_ff @(posedge clk) begin
    if (push) stk_q[cnt_q] <= cur_q;
  end

  assign cur_lvl = cur_q;
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
endmodule

// File: rtl/pvic_handshake.sv
// Request / acknowledge / vector sequencing toward the CPU.
module pvic_handshake
  import pvic_pkg::*;
#(
  parameter int          ID_W       = 3,
  parameter int          VEC_W      = 8,
  parameter int unsigned NMI_VECTOR = 252
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cand_valid,
  input  logic             cand_nmi,
  input  logic [ID_W-1:0]  cand_id,
  input  logic             cpu_ack,
  input  logic             eoi,
  input  logic [VEC_W-1:0] dev_vector,
  input  logic             stk_full,
  input  logic             stk_empty,
  output logic             take,
  output logic             pop,
  output logic             cpu_irq,
  output logic             ack_valid,
  output logic             ack_nmi,
  output logic [ID_W-1:0]  ack_num,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_out
);
  hs_state_e        state_q, state_n;
  logic             irq_q, irq_n;
  logic             akv_q, akv_n;
  logic             akn_q, akn_n;
  logic [ID_W-1:0]  num_q, num_n;
  logic             vv_q, vv_n;
  logic [VEC_W-1:0] vec_q, vec_n;

  always_comb begin
    // end-of-interrupt has precedence over an acknowledge in the same cycle
    take    = (state_q == HS_IDLE) && cpu_ack && cand_valid && !eoi && !stk_full;
    pop     = eoi && !stk_empty;
    state_n = take ? HS_ACK : HS_IDLE;
    irq_n   = (state_q == HS_IDLE) && cand_valid && !take;
    akv_n   = take;
    akn_n   = take ? cand_nmi : akn_q;
    num_n   = take ? cand_id : num_q;
    vv_n    = akv_q;
    vec_n   = vec_q;
    if (akv_q) vec_n = akn_q ? VEC_W'(NMI_VECTOR) : dev_vector;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      irq_q   <= 1'b0;
      akv_q   <= 1'b0;
      akn_q   <= 1'b0;
      num_q   <= '0;
      vv_q    <= 1'b0;
      vec_q   <= '0;
    end else begin
      state_q <= state_n;
      irq_q   <= irq_n;
      akv_q   <= akv_n;
      akn_q   <= akn_n;
      num_q   <= num_n;
      vv_q    <= vv_n;
      vec_q   <= vec_n;
    end
  end

  assign cpu_irq   = irq_q;
  assign ack_valid = akv_q;
  assign ack_nmi   = akn_q;
  assign ack_num   = num_q;
  assign vec_valid = vv_q;
  assign vec_out   = vec_q;
endmodule

// File: rtl/pvic_top.sv
module pvic_top #(
  parameter int          NUM_IRQ    = 8,
  parameter int          VEC_W      = 8,
  parameter int unsigned NMI_VECTOR = 252,
  localparam int         ID_W       = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               nmi_req,
  input  logic               cpu_ack,
  input  logic               eoi,
  input  logic [VEC_W-1:0]   dev_vector,
  output logic               cpu_irq,
  output logic               ack_valid,
  output logic [ID_W-1:0]    ack_num,
  output logic               ack_nmi,
  output logic               vec_valid,
  output logic [VEC_W-1:0]   vec_out
);
  localparam int IDLE_LVL = NUM_IRQ + 1;
  localparam int LVL_W    = $clog2(IDLE_LVL + 1);
  localparam int DEPTH    = NUM_IRQ + 1;

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             nmi_d, nmi_pend, nmi_pend_n;
  logic             cand_valid, cand_nmi;
  logic [ID_W-1:0]  cand_id;
  logic [LVL_W-1:0] cand_lvl, cur_lvl;
  logic             take, pop, stk_full, stk_empty;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // non-maskable edge latch, cleared when that request is accepted
  always_comb begin
    nmi_pend_n = nmi_pend;
    if (take && cand_nmi)   nmi_pend_n = 1'b0;
    if (nmi_req && !nmi_d)  nmi_pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      nmi_d    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_d    <= nmi_req;
      nmi_pend <= nmi_pend_n;
    end
  end

  pvic_arbiter #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W), .LVL_W(LVL_W)) u_arb (
    .irq        (irq_req),
    .nmi_pend   (nmi_pend),
    .cur_lvl    (cur_lvl),
    .cand_valid (cand_valid),
    .cand_nmi   (cand_nmi),
    .cand_id    (cand_id),
    .cand_lvl   (cand_lvl)
  );

  pvic_level_stack #(.LVL_W(LVL_W), .DEPTH(DEPTH), .IDLE_LVL(IDLE_LVL)) u_stk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .push     (take),
    .push_lvl (cand_lvl),
    .pop      (pop),
    .cur_lvl  (cur_lvl),
    .full     (stk_full),
    .empty    (stk_empty)
  );

  pvic_handshake #(.ID_W(ID_W), .VEC_W(VEC_W), .NMI_VECTOR(NMI_VECTOR)) u_hs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cand_valid (cand_valid),
    .cand_nmi   (cand_nmi),
    .cand_id    (cand_id),
    .cpu_ack    (cpu_ack),
    .eoi        (eoi),
    .dev_vector (dev_vector),
    .stk_full   (stk_full),
    .stk_empty  (stk_empty),
    .take       (take),
    .pop        (pop),
    .cpu_irq    (cpu_irq),
    .ack_valid  (ack_valid),
    .ack_nmi    (ack_nmi),
    .ack_num    (ack_num),
    .vec_valid  (vec_valid),
    .vec_out    (vec_out)
  );
endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
  parameter int          NUM_IRQ    = 8,
  parameter int          VEC_W      = 8,
  parameter int unsigned NMI_VECTOR = 252,
  parameter int          ID_W       = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_req,
  input logic               cpu_ack,
  input logic               eoi,
  input logic               cpu_irq,
  input logic               ack_valid,
  input logic [ID_W-1:0]    ack_num,
  input logic               ack_nmi,
  input logic               vec_valid,
  input logic [VEC_W-1:0]   vec_out
);
  logic [NUM_IRQ-1:0] irq_seen;
  logic [NUM_IRQ-1:0] more_urgent;

  always_ff @(posedge clk) irq_seen <= irq_req;

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) more_urgent[i] = (i < int'(ack_num));
  end

  a_r2_ack_needs_cpu_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(cpu_ack));
  a_r2_irq_low_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> !cpu_irq);
  a_r2_ack_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> !ack_valid);
  a_r3_acked_line_was_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_nmi) |-> irq_seen[ack_num]);
  a_r2_lowest_index_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_nmi) |-> ((irq_seen & more_urgent) == '0));
  a_r6_vec_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack_valid));
  a_r6_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_nmi) |=> (vec_valid && (vec_out == VEC_W'(NMI_VECTOR))));
  a_r8_eoi_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !ack_valid);
endmodule

bind pvic_top pvic_checker #(
  .NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W), .NMI_VECTOR(NMI_VECTOR), .ID_W(ID_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req),
  .cpu_ack   (cpu_ack),
  .eoi       (eoi),
  .cpu_irq   (cpu_irq),
  .ack_valid (ack_valid),
  .ack_num   (ack_num),
  .ack_nmi   (ack_nmi),
  .vec_valid (vec_valid),
  .vec_out   (vec_out)
);

// File: tb/tb_pvic_top.sv
module tb_pvic_top;
  localparam int NI  = 8;
  localparam int NMV = 252;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NI-1:0] irq_req;
  logic          nmi_req, cpu_ack, eoi;
  logic [7:0]    dev_vector;
  logic          cpu_irq, ack_valid, ack_nmi, vec_valid;
  logic [2:0]    ack_num;
  logic [7:0]    vec_out;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  // device model: the acknowledged device drives 0x40 + 4*number
  assign dev_vector = ack_valid ? 8'(32'h40 + 4 * int'(ack_num)) : 8'hEE;

  pvic_top #(.NUM_IRQ(NI), .VEC_W(8), .NMI_VECTOR(NMV)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
    .cpu_ack(cpu_ack), .eoi(eoi), .dev_vector(dev_vector),
    .cpu_irq(cpu_irq), .ack_valid(ack_valid), .ack_num(ack_num),
    .ack_nmi(ack_nmi), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // acknowledge now; expects an eligible request
  task automatic do_take(input logic exp_nmi, input int exp_id, input string tag);
    int exp_vec;
    exp_vec = exp_nmi ? NMV : (32'h40 + 4 * exp_id);
    cpu_ack = 1'b1;
    step();
    cpu_ack = 1'b0;
    check({tag, " R2 ack_valid"}, 32'(ack_valid), 32'd1);
    check({tag, " R2 ack_num"},   32'(ack_num), exp_nmi ? 32'd0 : 32'(exp_id));
    check({tag, " R5 ack_nmi"},   32'(ack_nmi), 32'(exp_nmi));
    check({tag, " R2 cpu_irq low"}, 32'(cpu_irq), 32'd0);
    step();
    check({tag, " R6 vec_valid"}, 32'(vec_valid), 32'd1);
    check({tag, " R6 vec_out"},   32'(vec_out), 32'(exp_vec));
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    step();
    eoi = 1'b0;
  endtask

  function automatic int lowest(input int p);
    for (int i = 0; i < NI; i++) if (p[i]) return i;
    return -1;
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; nmi_req = 1'b0; cpu_ack = 1'b0; eoi = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1: quiet after reset, nothing in service
    check("R1 cpu_irq",   32'(cpu_irq), 32'd0);
    check("R1 ack_valid", 32'(ack_valid), 32'd0);
    check("R1 vec_valid", 32'(vec_valid), 32'd0);
    irq_req = 8'h80; step();
    check("R1 idle accepts lowest line", 32'(cpu_irq), 32'd1);
    irq_req = '0; step();

    // R7: acknowledge with nothing eligible
    cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
    check("R7 no ack when idle", 32'(ack_valid), 32'd0);
    step();
    check("R7 no vector when idle", 32'(vec_valid), 32'd0);

    // R2: every request pattern from idle
    for (int p = 0; p < 256; p++) begin
      irq_req = 8'(p);
      step();
      check("R2 cpu_irq sweep", 32'(cpu_irq), 32'(p != 0));
      if (p != 0) begin
        do_take(1'b0, lowest(p), "sweep");
        irq_req = '0;
        do_eoi();
      end
      step();
    end

    // R3: every pattern against each level in service
    for (int s = 0; s < NI; s++) begin
      irq_req = 8'(1 << s);
      step();
      do_take(1'b0, s, "mask");
      for (int p = 0; p < 256; p++) begin
        irq_req = 8'(p);
        step();
        check("R3 masking", 32'(cpu_irq), 32'((p & ((1 << s) - 1)) != 0));
      end
      // R7: acknowledge while only masked lines are raised
      irq_req = 8'(1 << s);
      step();
      cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
      check("R7 masked ack ignored", 32'(ack_valid), 32'd0);
      irq_req = '0;
      do_eoi();
      step();
    end

    // R4: nesting and return
    irq_req = 8'h80; step(); do_take(1'b0, 7, "nest7");
    step();
    check("R6 vec_valid one cycle", 32'(vec_valid), 32'd0);
    irq_req = 8'h04; step();
    check("R4 nest outranks", 32'(cpu_irq), 32'd1);
    do_take(1'b0, 2, "nest2");
    irq_req = 8'h01; step(); do_take(1'b0, 0, "nest0");
    irq_req = '0; do_eoi();
    irq_req = 8'h02; step();
    check("R4 restored level 2 admits 1", 32'(cpu_irq), 32'd1);
    irq_req = 8'h04; step();
    check("R4 restored level 2 holds 2", 32'(cpu_irq), 32'd0);
    irq_req = '0; do_eoi();
    irq_req = 8'h40; step();
    check("R4 restored level 7 admits 6", 32'(cpu_irq), 32'd1);
    irq_req = 8'h80; step();
    check("R4 restored level 7 holds 7", 32'(cpu_irq), 32'd0);
    irq_req = '0; do_eoi();
    irq_req = 8'h80; step();
    check("R4 back to idle", 32'(cpu_irq), 32'd1);
    irq_req = '0; do_eoi();
    step();
    irq_req = 8'h80; step();
    check("R4 extra eoi ignored", 32'(cpu_irq), 32'd1);
    irq_req = '0; step();

    // R5: non-maskable over the most urgent line
    irq_req = 8'h01; step(); do_take(1'b0, 0, "pre_nmi");
    irq_req = '0;
    nmi_req = 1'b1; step(); step();
    check("R5 nmi over level 1", 32'(cpu_irq), 32'd1);
    do_take(1'b1, 0, "nmi");
    nmi_req = 1'b0; step();
    nmi_req = 1'b1; step(); step();
    check("R5 nmi waits during nmi", 32'(cpu_irq), 32'd0);
    do_eoi(); step();
    check("R5 pending nmi after eoi", 32'(cpu_irq), 32'd1);
    do_take(1'b1, 0, "nmi2");
    do_eoi(); do_eoi(); step(); step();
    check("R5 held level no retrigger", 32'(cpu_irq), 32'd0);
    nmi_req = 1'b0; step();

    // R8: eoi and acknowledge together
    irq_req = 8'h10; step();
    check("R8 setup", 32'(cpu_irq), 32'd1);
    cpu_ack = 1'b1; eoi = 1'b1; step(); cpu_ack = 1'b0; eoi = 1'b0;
    check("R8 ack dropped", 32'(ack_valid), 32'd0);
    check("R8 request kept", 32'(cpu_irq), 32'd1);
    do_take(1'b0, 4, "after_r8");
    irq_req = '0; do_eoi(); step();

    summary();
    $finish;
  end
endmodule